// File: doc/BRIEF.md
# Approximate Divide-and-Conquer Multiplier

This block is a purely combinational unsigned multiplier. By default it takes two 8-bit operands and returns their 16-bit product. Each operand is cut into a low and a high half. Four half-by-half sub-products are formed and then shifted into place and summed with exact ripple addition.

Each sub-multiplier forms its partial products by ANDing. It then adds them either exactly or approximately. In the approximate form, the lowest result columns are built from carry-free cells. Each such column becomes the OR of its partial-product bits and passes no carry upward. Every column above that region is summed exactly.

A parameter mask selects which of the four sub-products use the approximate form. By default only the low-by-low sub-product is approximate. All of its error is therefore confined to small weights. The block suits error-tolerant signal and image datapaths, where trimming carry logic in the least significant region matters more than bit accuracy.

Top module: `amul_dnc`

## Requirements
- R1: The product equals HH<<8 + (HL + LH)<<4 + LL, summed exactly. HH = aH·bH, HL = aH·bL, LH = aL·bH and LL = aL·bL, where aH/aL are op_a[7:4]/op_a[3:0] and bH/bL are op_b[7:4]/op_b[3:0].
- R2: Inside every sub-multiplier, the partial product of row i is the multiplicand half ANDed with bit i of the multiplier half, placed at weight 2^i.
- R3: In an approximate sub-multiplier, each result column below APPROX_COLS (default 3) is the OR of that column's partial-product bits, and no carry leaves that region.
- R4: In an approximate sub-multiplier, all partial-product bits in columns at or above APPROX_COLS are summed exactly. An exact sub-multiplier returns the true 4x4 product.
- R5: APPROX_MASK bit 0 selects LL, bit 1 HL, bit 2 LH and bit 3 HH as approximate. The default 4'b0001 makes only LL approximate.
- R6: If either operand is zero, the product is zero.
- R7: When every approximate sub-product has a zero operand half (by default aL = 0 or bL = 0), the product equals the exact product.
- R8: The product never exceeds the exact product of the operands.
- R9: The product follows the operands with no clocked latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*HALF_W (8) | Unsigned multiplicand |
| op_b | input | 2*HALF_W (8) | Unsigned multiplier |
| product | output | 4*HALF_W (16) | Approximate unsigned product |

## Verification
The bench sweeps every operand pair and checks the result against a behavioural model with the same approximation choices. It also hand-checks several values. With 0x03·0x03 the column-1 bits must OR to 7 rather than carry to 9, so a design that kept the carry would return the exact value. With 0xFF·0xFF the result must be 65015, which a wrong column boundary would shift. Operands with a zero low half must give exact products, so an approximation that leaks into HL, LH or HH shows up there. Zero operands and the no-overshoot bound are checked on every vector; a design that OR-ed the wrong columns or dropped a high-column carry breaks one of them.

// File: rtl/amul_pkg.sv
package amul_pkg;

   // Sub-product slots; bit q of APPROX_MASK selects slot q as approximate.
   localparam int unsigned NUM_SUB = 4;

   typedef enum logic [1:0] {
      SUB_LL = 2'd0,
      SUB_HL = 2'd1,
      SUB_LH = 2'd2,
      SUB_HH = 2'd3
   } sub_slot_e;

   // Which half of operand A feeds slot q (0 = low, 1 = high).
   function automatic int unsigned a_half_of(int unsigned q);
      return q % 2;
   endfunction

   // Which half of operand B feeds slot q (0 = low, 1 = high).
   function automatic int unsigned b_half_of(int unsigned q);
      return q / 2;
   endfunction

endpackage

// File: rtl/amul_rca.sv
// Exact ripple-carry adder built from full-adder cells; carry out of the top bit is dropped.
module amul_rca #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   logic [W-1:0] c;

   assign c[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_cell
      assign sum[i] = a[i] ^ b[i] ^ c[i];
      if (i < W - 1) begin : g_carry
         assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
      end
   end

endmodule

// File: rtl/amul_sub.sv
// HW x HW sub-multiplier. APPROX selects the carry-free low-column variant.
module amul_sub #(
   parameter int unsigned HW          = 4,
   parameter bit          APPROX      = 1'b0,
   parameter int unsigned APPROX_COLS = 3,
   localparam int unsigned PW         = 2 * HW
) (
   input  logic [HW-1:0] x,
   input  logic [HW-1:0] y,
   output logic [PW-1:0] p
);
   localparam int unsigned KC = APPROX ? APPROX_COLS : 0;
   localparam logic [PW-1:0] LO_MASK = PW'((64'd1 << KC) - 64'd1);
   localparam logic [PW-1:0] HI_MASK = ~LO_MASK;

   if (HW < 1) begin : g_bad_hw
      $error("amul_sub: HW must be at least 1");
   end
   if (APPROX && (APPROX_COLS > PW - 1)) begin : g_bad_cols
      $error("amul_sub: APPROX_COLS exceeds the column count");
   end

   // Partial-product rows (AND of multiplicand with one multiplier bit), shifted.
   logic [PW-1:0] row    [HW];
   logic [PW-1:0] row_hi [HW];
   logic [PW-1:0] acc    [HW];
   logic [PW-1:0] lo_bits;

   for (genvar i = 0; i < HW; i++) begin : g_row
      assign row[i]    = PW'(x & {HW{y[i]}}) << i;
      assign row_hi[i] = row[i] & HI_MASK;
   end

   // Exact accumulation of everything at or above the approximate columns.
   assign acc[0] = row_hi[0];
   for (genvar i = 1; i < HW; i++) begin : g_acc
      amul_rca #(.W(PW)) u_add (
         .a   (acc[i-1]),
         .b   (row_hi[i]),
         .sum (acc[i])
      );
   end

   if (KC > 0) begin : g_approx
      // Carry-free cells: each low column collapses to the OR of its bits.
      logic [PW-1:0] lo_acc [HW];
      assign lo_acc[0] = row[0] & LO_MASK;
      for (genvar i = 1; i < HW; i++) begin : g_or
         assign lo_acc[i] = lo_acc[i-1] | (row[i] & LO_MASK);
      end
      assign lo_bits = lo_acc[HW-1];

      always_comb begin
         AST_SUB_BOUND: assert (p <= PW'(x) * PW'(y)); // R8
      end
   end else begin : g_exact
      assign lo_bits = '0;

      always_comb begin
         AST_SUB_EXACT: assert (p == PW'(x) * PW'(y)); // R4
      end
   end

   // Low region and exact high region do not overlap, so OR joins them.
   assign p = acc[HW-1] | lo_bits;

endmodule

// File: rtl/amul_dnc.sv
// Divide-and-conquer unsigned multiplier from four half-width sub-multipliers.
module amul_dnc
   import amul_pkg::*;
#(
   parameter int unsigned HALF_W       = 4,
   parameter logic [3:0]  APPROX_MASK  = 4'b0001,
   parameter int unsigned APPROX_COLS  = 3,
   localparam int unsigned OPW         = 2 * HALF_W,
   localparam int unsigned PROD_W      = 2 * OPW
) (
   input  logic [OPW-1:0]    op_a,
   input  logic [OPW-1:0]    op_b,
   output logic [PROD_W-1:0] product
);
   localparam int unsigned SUB_W = 2 * HALF_W;
   localparam int unsigned MID_W = SUB_W + 1;

   if (HALF_W < 1 || HALF_W > 15) begin : g_bad_half
      $error("amul_dnc: HALF_W out of range");
   end
   if (APPROX_COLS > SUB_W - 1) begin : g_bad_cols
      $error("amul_dnc: APPROX_COLS out of range");
   end

   logic [SUB_W-1:0] sub_p [NUM_SUB];
   logic [NUM_SUB-1:0] approx_live;

   for (genvar q = 0; q < NUM_SUB; q++) begin : g_sub
      localparam int unsigned AOFF = a_half_of(q) * HALF_W;
      localparam int unsigned BOFF = b_half_of(q) * HALF_W;
      logic [HALF_W-1:0] xa, yb;
      assign xa = op_a[AOFF +: HALF_W];
      assign yb = op_b[BOFF +: HALF_W];
      assign approx_live[q] = APPROX_MASK[q] && (xa != '0) && (yb != '0);

      amul_sub #(
         .HW          (HALF_W),
         .APPROX      (APPROX_MASK[q]),
         .APPROX_COLS (APPROX_COLS)
      ) u_sub (
         .x (xa),
         .y (yb),
         .p (sub_p[q])
      );
   end

   // Middle terms share one weight; sum them with an extra carry bit.
   logic [MID_W-1:0] mid;
   amul_rca #(.W(MID_W)) u_mid (
      .a   ({1'b0, sub_p[SUB_HL]}),
      .b   ({1'b0, sub_p[SUB_LH]}),
      .sum (mid)
   );

   // HH and LL occupy disjoint bit ranges, so they concatenate without an adder.
   logic [PROD_W-1:0] outer, mid_shift;
   assign outer     = {sub_p[SUB_HH], sub_p[SUB_LL]};
   assign mid_shift = PROD_W'(mid) << HALF_W;

   amul_rca #(.W(PROD_W)) u_final (
      .a   (outer),
      .b   (mid_shift),
      .sum (product)
   );

   logic [PROD_W-1:0] exact_p;
   assign exact_p = PROD_W'(op_a) * PROD_W'(op_b);

   always_comb begin
      if (op_a == '0 || op_b == '0) begin
         AST_ZERO_OPERAND: assert (product == '0); // R6
      end
      AST_NO_OVERSHOOT: assert (product <= exact_p); // R8
      if (approx_live == '0) begin
         AST_EXACT_WHEN_CLEAN: assert (product == exact_p); // R7
      end
   end

endmodule

// File: tb/tb_amul_dnc.sv
module tb_amul_dnc;
   localparam int HW   = 4;
   localparam int KCOL = 3;
   localparam logic [3:0] MASK = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  a = '0, b = '0;
   logic [15:0] prod;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   amul_dnc #(.HALF_W(HW), .APPROX_MASK(MASK), .APPROX_COLS(KCOL)) dut (
      .op_a (a), .op_b (b), .product (prod)
   );

   // Behavioural model: column bookkeeping with integers.
   function automatic int ref_sub(int x, int y, bit apx);
      int hi = 0, lo = 0;
      for (int i = 0; i < HW; i++)
         for (int j = 0; j < HW; j++)
            if (((x >> j) & 1) && ((y >> i) & 1)) begin
               if (apx && (i + j) < KCOL) lo |= (1 << (i + j));
               else hi += (1 << (i + j));
            end
      return hi + lo;
   endfunction

   function automatic int ref_prod(int x, int y);
      int ll, hl, lh, hh;
      ll = ref_sub(x & 15, y & 15, MASK[0]);
      hl = ref_sub(x >> 4, y & 15, MASK[1]);
      lh = ref_sub(x & 15, y >> 4, MASK[2]);
      hh = ref_sub(x >> 4, y >> 4, MASK[3]);
      return (hh << 8) + ((hl + lh) << 4) + ll;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, a, b, act, exp);
      end
   endtask

   // R9: inputs change at posedge, result sampled at the following negedge.
   task automatic apply(logic [7:0] x, logic [7:0] y);
      @(posedge clk);
      a = x; b = y;
      @(negedge clk);
   endtask

   task automatic directed(logic [7:0] x, logic [7:0] y, int exp, string tag);
      apply(x, y);
      check(tag, int'(prod), exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 reset zero inputs", int'(prod), 0);

      directed(8'h03, 8'h03, 7,     "R3 column OR no carry");
      directed(8'h0F, 8'h0F, 215,   "R3 R4 low-low worst");
      directed(8'hFF, 8'hFF, 65015, "R1 R3 full scale");
      directed(8'h0C, 8'h0C, 144,   "R4 high columns exact");
      directed(8'h01, 8'h01, 1,     "R2 single bit");
      directed(8'hF0, 8'h0F, 3600,  "R7 aL zero exact");
      directed(8'h10, 8'h10, 256,   "R5 HH exact");
      directed(8'h00, 8'hFF, 0,     "R6 a zero");
      directed(8'hA5, 8'h00, 0,     "R6 b zero");
      directed(8'h35, 8'hA0, 8480,  "R5 R7 bL zero exact");

      // Exhaustive sweep against the model, with bound and exactness checks.
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            apply(8'(x), 8'(y));
            check("R1 R2 R5 model", int'(prod), ref_prod(x, y));
            checks++;
            if (int'(prod) > x * y) begin
               errors++;
               $display("FAIL R8 a=%0d b=%0d actual=%0d expected<=%0d", x, y, prod, x * y);
            end
            if (x == 0 || y == 0) check("R6 zero", int'(prod), 0);
            else if ((x & 15) == 0 || (y & 15) == 0) check("R7 exact", int'(prod), x * y);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule